// File: doc/BRIEF.md
# Generalized Asymmetric C-Element

This block is a state-holding gate with one output. Its inputs fall into three groups. The unmarked group takes part in both the rising and the falling decision. The plus group is consulted only when deciding to go high. The minus group is consulted only when deciding to go low. The output rises once every unmarked and every plus input is 1. It falls once every unmarked and every minus input is 0. In any other case it keeps its value.

A typical use is inside a pipeline stage, where it acts as the completion detector that raises an early "done" indication. The element is built as a clocked register fed by next-state logic, so all decisions are taken at a clock edge. Group sizes are parameters. A symmetric mode turns the block into a plain Muller C-element over the unmarked inputs and ignores the plus and minus groups.

Top module: `acel_gate`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `state_o` takes the value of parameter `INIT_VAL` at that edge. Reset takes priority over every input condition.
- R2: When every unmarked input and every plus input is 1 at a rising edge, `state_o` is 1 after that edge.
- R3: When every unmarked input and every minus input is 0 at a rising edge, `state_o` is 0 after that edge.
- R4: When neither the R2 condition nor the R3 condition holds at a rising edge, `state_o` keeps its previous value.
- R5: The values on `plus_i` have no effect on the falling decision.
- R6: The values on `minus_i` have no effect on the rising decision.
- R7: A plus or minus group with zero members counts as satisfied. Its port is then one bit wide and that bit is ignored.
- R8: With `SYMMETRIC`=1, `state_o` goes to 1 when all unmarked inputs are 1 and to 0 when all are 0, and holds otherwise. `plus_i` and `minus_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every decision is taken at its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| both_i | input | N_BOTH | Unmarked inputs, used for both edges (N_BOTH ≥ 1) |
| plus_i | input | max(1,N_PLUS) | Inputs used only for the rising decision |
| minus_i | input | max(1,N_MINUS) | Inputs used only for the falling decision |
| state_o | output | 1 | Registered element output |

## Verification
The bench builds three copies of the block.

- The first has one unmarked input, two plus inputs and one minus input. Its separate groups let the bench show that each marked group is blind to the opposite edge.
- The second is symmetric with two unmarked inputs and an initial value of 1. It is driven from a vector table that checks hold behaviour, and checks that plus and minus inputs are ignored.
- The third has two unmarked inputs and an empty plus group. It shows that the empty condition counts as met.

For the first and third copies, every input combination is applied from both prior output values and compared with a reference model.

// File: rtl/acel_pkg.sv
package acel_pkg;

    typedef struct packed {
        logic out;
    } acel_state_t;

    function automatic int unsigned acel_port_w(input int unsigned members);
        return (members == 0) ? 1 : members;
    endfunction

endpackage

// File: rtl/acel_group_eval.sv
module acel_group_eval #(
    parameter int unsigned MEMBERS = 1,
    parameter int unsigned PORT_W  = (MEMBERS == 0) ? 1 : MEMBERS
) (
    input  logic [PORT_W-1:0] grp_i,
    output logic              all_hi_o,
    output logic              all_lo_o
);

    generate
        if (MEMBERS == 0) begin : g_empty
            // An empty group never blocks its condition; the placeholder bit is ignored.
            assign all_hi_o = (&grp_i) | 1'b1;
            assign all_lo_o = (|grp_i) | 1'b1;
        end else begin : g_real
            assign all_hi_o = &grp_i;
            assign all_lo_o = ~|grp_i;
        end
    endgenerate

endmodule

// File: rtl/acel_cond.sv
module acel_cond #(
    parameter bit SYMMETRIC = 1'b0
) (
    input  logic both_hi_i,
    input  logic both_lo_i,
    input  logic plus_hi_i,
    input  logic minus_lo_i,
    output logic set_o,
    output logic clr_o
);

    logic plus_ok;
    logic minus_ok;

    always_comb begin
        plus_ok  = SYMMETRIC ? 1'b1 : plus_hi_i;
        minus_ok = SYMMETRIC ? 1'b1 : minus_lo_i;
        set_o    = both_hi_i & plus_ok;
        clr_o    = both_lo_i & minus_ok;
    end

endmodule

// File: rtl/acel_gate.sv
module acel_gate
    import acel_pkg::*;
#(
    parameter int unsigned N_BOTH    = 2,
    parameter int unsigned N_PLUS    = 1,
    parameter int unsigned N_MINUS   = 1,
    parameter bit          SYMMETRIC = 1'b0,
    parameter bit          INIT_VAL  = 1'b0,
    localparam int unsigned PLUS_W   = (N_PLUS == 0) ? 1 : N_PLUS,
    localparam int unsigned MINUS_W  = (N_MINUS == 0) ? 1 : N_MINUS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_BOTH-1:0]  both_i,
    input  logic [PLUS_W-1:0]  plus_i,
    input  logic [MINUS_W-1:0] minus_i,
    output logic               state_o
);

    generate
        if (N_BOTH < 1) begin : g_bad_cfg
            $error("acel_gate needs at least one unmarked input");
        end
    endgenerate

    logic both_hi, both_lo;
    logic plus_hi, plus_lo;
    logic minus_hi, minus_lo;
    logic set_c, clr_c;

    acel_state_t st_d, st_q;

    acel_group_eval #(.MEMBERS(N_BOTH), .PORT_W(N_BOTH)) u_both (
        .grp_i    (both_i),
        .all_hi_o (both_hi),
        .all_lo_o (both_lo)
    );

    acel_group_eval #(.MEMBERS(N_PLUS), .PORT_W(PLUS_W)) u_plus (
        .grp_i    (plus_i),
        .all_hi_o (plus_hi),
        .all_lo_o (plus_lo)
    );

    acel_group_eval #(.MEMBERS(N_MINUS), .PORT_W(MINUS_W)) u_minus (
        .grp_i    (minus_i),
        .all_hi_o (minus_hi),
        .all_lo_o (minus_lo)
    );

    acel_cond #(.SYMMETRIC(SYMMETRIC)) u_cond (
        .both_hi_i  (both_hi),
        .both_lo_i  (both_lo),
        .plus_hi_i  (plus_hi),
        .minus_lo_i (minus_lo),
        .set_o      (set_c),
        .clr_o      (clr_c)
    );

    // The plus group's low flag and the minus group's high flag drive no decision (R5, R6).
    logic unused_flags;
    assign unused_flags = plus_lo ^ minus_hi;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.out = INIT_VAL;
        end else if (set_c) begin
            st_d.out = 1'b1;
        end else if (clr_c) begin
            st_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign state_o = st_q.out;

    logic seen_edge_q;
    always_ff @(posedge clk) begin
        seen_edge_q <= 1'b1;
    end

    assert_reset_value_R1: assert property (@(posedge clk)
        seen_edge_q && rst |=> state_o == INIT_VAL);

    assert_rise_R2: assert property (@(posedge clk) disable iff (rst)
        set_c |=> state_o);

    assert_fall_R3: assert property (@(posedge clk) disable iff (rst)
        clr_c |=> !state_o);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        seen_edge_q && !set_c && !clr_c && !$past(rst) |=> $stable(state_o));

    // With at least one unmarked input, the two conditions can never both hold (R2, R3).
    assert_set_clr_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(set_c && clr_c));

endmodule

// File: tb/acel_gate_tb_top.sv
`timescale 1ns/1ps
module acel_gate_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Copy A: 1 unmarked, 2 plus, 1 minus, init 0
    logic [0:0] a_both;
    logic [1:0] a_plus;
    logic [0:0] a_minus;
    logic       a_out;
    // Copy B: symmetric, 2 unmarked, init 1
    logic [1:0] b_both;
    logic [0:0] b_plus;
    logic [0:0] b_minus;
    logic       b_out;
    // Copy C: 2 unmarked, empty plus group, 1 minus, init 0
    logic [1:0] c_both;
    logic [0:0] c_plus;
    logic [0:0] c_minus;
    logic       c_out;

    acel_gate #(.N_BOTH(1), .N_PLUS(2), .N_MINUS(1), .SYMMETRIC(1'b0), .INIT_VAL(1'b0)) dut_i (
        .clk(clk), .rst(rst), .both_i(a_both), .plus_i(a_plus), .minus_i(a_minus), .state_o(a_out));

    acel_gate #(.N_BOTH(2), .N_PLUS(1), .N_MINUS(1), .SYMMETRIC(1'b1), .INIT_VAL(1'b1)) dut_sym_i (
        .clk(clk), .rst(rst), .both_i(b_both), .plus_i(b_plus), .minus_i(b_minus), .state_o(b_out));

    acel_gate #(.N_BOTH(2), .N_PLUS(0), .N_MINUS(1), .SYMMETRIC(1'b0), .INIT_VAL(1'b0)) dut_empty_i (
        .clk(clk), .rst(rst), .both_i(c_both), .plus_i(c_plus), .minus_i(c_minus), .state_o(c_out));

    // Symmetric copy vectors: [4:3] unmarked, [2] plus, [1] minus, [0] expected output
    localparam logic [4:0] SYM_TBL [8] = '{
        5'b10_1_1_1,
        5'b00_1_1_0,
        5'b01_0_0_0,
        5'b11_0_0_1,
        5'b10_0_0_1,
        5'b00_0_1_0,
        5'b11_1_0_1,
        5'b01_1_1_1
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Inputs change at the falling edge; the register takes them at the next
    // rising edge; the output is sampled at the falling edge after that.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        a_both = '0; a_plus = '0; a_minus = '0;
        b_both = '0; b_plus = '0; b_minus = '0;
        c_both = '0; c_plus = '0; c_minus = '0;
        rst = 1'b1;
        @(negedge clk);
        tick();
        chk("R1", "reset A", a_out, 1'b0);
        chk("R1", "reset B", b_out, 1'b1);
        chk("R1", "reset C", c_out, 1'b0);

        // Reset wins over a rising condition (R1).
        a_both = 1'b1; a_plus = 2'b11;
        c_both = 2'b11;
        tick();
        chk("R1", "reset over set A", a_out, 1'b0);
        chk("R1", "reset over set C", c_out, 1'b0);
        rst = 1'b0;

        // Symmetric table walk (R8)
        for (int i = 0; i < 8; i++) begin
            b_both  = SYM_TBL[i][4:3];
            b_plus  = SYM_TBL[i][2];
            b_minus = SYM_TBL[i][1];
            tick();
            chk("R8", $sformatf("sym vector %0d", i), b_out, SYM_TBL[i][0]);
        end

        // Every input combination from both prior states, copies A and C.
        // A: v[0] unmarked, v[2:1] plus, v[3] minus.
        // C: v[1:0] unmarked, v[2] plus (group empty), v[3] minus.
        for (int prev = 0; prev < 2; prev++) begin
            for (int v = 0; v < 16; v++) begin
                logic a_set, a_clr, a_exp, c_set, c_clr, c_exp;
                string a_tag, c_tag;
                if (prev == 1) begin
                    a_both = 1'b1; a_plus = 2'b11; a_minus = 1'b1;
                    c_both = 2'b11; c_plus = 1'b0; c_minus = 1'b1;
                end else begin
                    a_both = 1'b0; a_plus = 2'b00; a_minus = 1'b0;
                    c_both = 2'b00; c_plus = 1'b1; c_minus = 1'b0;
                end
                tick();
                a_both  = v[0];
                a_plus  = v[2:1];
                a_minus = v[3];
                c_both  = v[1:0];
                c_plus  = v[2];
                c_minus = v[3];
                a_set = v[0] & v[1] & v[2];
                a_clr = !v[0] & !v[3];
                a_exp = a_set ? 1'b1 : (a_clr ? 1'b0 : prev[0]);
                a_tag = a_set ? "R2" : (a_clr ? "R3" : "R4");
                c_set = v[0] & v[1];
                c_clr = !v[0] & !v[1] & !v[3];
                c_exp = c_set ? 1'b1 : (c_clr ? 1'b0 : prev[0]);
                c_tag = c_set ? "R7" : (c_clr ? "R3" : "R4");
                tick();
                chk(a_tag, $sformatf("A prev=%0d v=%0d", prev, v), a_out, a_exp);
                chk(c_tag, $sformatf("C prev=%0d v=%0d", prev, v), c_out, c_exp);
            end
        end

        // R5: plus inputs all high do not stop a fall
        a_both = 1'b1; a_plus = 2'b11; a_minus = 1'b1;
        tick();
        a_both = 1'b0; a_plus = 2'b11; a_minus = 1'b0;
        tick();
        chk("R5", "fall with plus high", a_out, 1'b0);

        // R6: minus inputs all low do not stop a rise
        a_both = 1'b1; a_plus = 2'b11; a_minus = 1'b0;
        tick();
        chk("R6", "rise with minus low", a_out, 1'b1);

        // R6: minus high does not complete a rise when plus is incomplete
        a_both = 1'b0; a_plus = 2'b00; a_minus = 1'b0;
        tick();
        a_both = 1'b1; a_plus = 2'b01; a_minus = 1'b1;
        tick();
        chk("R6", "no rise from minus group", a_out, 1'b0);

        // R7: empty plus group, unmarked high alone raises C
        c_both = 2'b00; c_minus = 1'b0;
        tick();
        c_both = 2'b11; c_plus = 1'b0;
        tick();
        chk("R7", "empty plus group satisfied", c_out, 1'b1);

        // R1 again mid-run: B returns to 1, A to 0
        b_both = 2'b00;
        tick();
        chk("R8", "sym clear before reset", b_out, 1'b0);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1", "mid-run reset B", b_out, 1'b1);
        chk("R1", "mid-run reset A", a_out, 1'b0);

        finish_run();
    end

endmodule